// File: doc/BRIEF.md
# Direct-Mapped Tile Cache Array

This block keeps whole operand tiles on chip. It has a fixed number of sets, and each set holds one tile of `TILE_WORDS` words together with one tag and one valid bit. A controller outside the block asks whether a tile is resident by presenting its tag on the lookup port. The answer comes back combinationally in the same cycle, so the controller can choose between streaming from the cache and fetching from memory without losing a cycle.

Fetched words are written one per cycle through the fill port. A separate commit strobe then installs the tile's tag and marks the set valid. A tile therefore becomes visible to lookups only after all of its words have been written. Resident words are read back through a registered read port with one cycle of latency.

The set is chosen by the low bits of the tag (direct mapping). Two saturating counters record lookup hits and lookup misses.

Top module: `tile_cache_array`

## Requirements
- R1: A word written through the fill port at set `s`, word `w` (with `w < TILE_WORDS`) is stored at linear position `s*TILE_WORDS + w`. A later read of the same set and word returns it.
- R2: The set of a tag is its low `log2(NUM_SETS)` bits. Tags that share those bits alias to the same set, and committing one of them evicts the other.
- R3: `lk_hit` is high in the same cycle as the lookup exactly when `lk_valid` is high, the set is valid, and the stored tag equals `lk_tag`. When `lk_valid` is low, `lk_hit` is low.
- R4: Reset clears every valid bit, so every lookup misses afterwards. Reset does not clear stored words or tags.
- R5: Fill words change no tag and no valid bit. A commit writes `fl_tag` into set `fl_tag[SET_W-1:0]` and sets that set's valid bit, taking effect from the next cycle.
- R6: `rd_data` is updated on the clock edge that samples `rd_en` high and holds while `rd_en` is low. A read and a fill write to the same word in the same cycle return the old word.
- R7: `hit_count` and `miss_count` are 0 after reset. Each increases by one on the clock edge after a lookup with `lk_valid` high that hits or misses, respectively. A cycle with `lk_valid` low changes neither.
- R8: Both counters are `CNT_WIDTH` bits wide (default 32) and hold at all-ones instead of wrapping.
- R9: When a commit and a lookup fall in the same cycle, the lookup sees the tag and valid state from before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_tag | input | TAG_WIDTH | Tag being looked up |
| lk_hit | output | 1 | Combinational hit for the current lookup |
| rd_en | input | 1 | Read enable |
| rd_set | input | SET_W | Set to read |
| rd_word | input | WORD_W | Word within the tile to read |
| rd_data | output | WORD_WIDTH | Registered read data |
| fl_we | input | 1 | Fill word write enable |
| fl_set | input | SET_W | Set being filled |
| fl_word | input | WORD_W | Word within the tile being filled |
| fl_data | input | WORD_WIDTH | Fill word |
| fl_commit | input | 1 | Commit strobe: install tag, set valid |
| fl_tag | input | TAG_WIDTH | Tag installed by the commit |
| hit_count | output | CNT_WIDTH | Saturating lookup hit count |
| miss_count | output | CNT_WIDTH | Saturating lookup miss count |

## Verification
The hit output is due in the cycle of the lookup itself. The bench drives each lookup just after a falling edge and samples `lk_hit` one time step later, before the next rising edge. Read data, counter values and the effect of a commit are all due one rising edge after their stimulus, so the bench drops the strobes just after that edge and samples at the following falling edge. Counters are compared before every lookup against a saturating count kept in the bench, which checks each single step as well as the hold at all-ones. The small configuration (four sets, 4-bit tags, 4-bit counters) lets the bench sweep every tag and every word and drive the counters into saturation.

// File: rtl/tcache_pkg.sv
package tcache_pkg;

   // Index width for a structure of n entries; never below one bit.
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/tcache_sat_counter.sv
module tcache_sat_counter #(
   parameter int unsigned CNT_WIDTH = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 inc,
   output logic [CNT_WIDTH-1:0] count
);

   localparam logic [CNT_WIDTH-1:0] CNT_MAX = '1;

   logic [CNT_WIDTH-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (inc && (cnt_q != CNT_MAX))
         cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;

   // R8: once at the top the count stays there until reset
   a_r8_hold_at_max: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

   // R7: an increment below the top advances by exactly one
   a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
      (inc && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R7: no increment, no change
   a_r7_idle_stable: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(cnt_q));

endmodule

// File: rtl/tcache_tag_store.sv
module tcache_tag_store
   import tcache_pkg::*;
#(
   parameter int unsigned NUM_SETS  = 4,
   parameter int unsigned TAG_WIDTH = 8,
   localparam int unsigned SET_W    = idx_w(NUM_SETS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 lk_valid,
   input  logic [TAG_WIDTH-1:0] lk_tag,
   output logic                 lk_hit,
   input  logic                 cm_en,
   input  logic [TAG_WIDTH-1:0] cm_tag
);

   logic [TAG_WIDTH-1:0] tag_q [NUM_SETS];
   logic [NUM_SETS-1:0]  valid_q;
   logic [NUM_SETS-1:0]  way_match;
   logic [SET_W-1:0]     lk_set;
   logic [SET_W-1:0]     cm_set;

   assign lk_set = lk_tag[SET_W-1:0];
   assign cm_set = cm_tag[SET_W-1:0];

   // Only the valid bits see reset; tag contents survive it.
   always_ff @(posedge clk) begin
      if (rst)
         valid_q <= '0;
      else if (cm_en)
         valid_q[cm_set] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (cm_en)
         tag_q[cm_set] <= cm_tag;
   end

   // One comparator per set, qualified by the direct-mapped index.
   for (genvar s = 0; s < NUM_SETS; s++) begin : g_cmp
      assign way_match[s] = (lk_set == SET_W'(s)) && valid_q[s] &&
                            (tag_q[s] == lk_tag);
   end

   assign lk_hit = lk_valid && (|way_match);

   // R4: reset leaves no set valid
   a_r4_reset_clears_valid: assert property (@(posedge clk)
      rst |=> (valid_q == '0));

   // R5: a commit installs the tag and validates its set
   a_r5_commit_installs: assert property (@(posedge clk) disable iff (rst)
      cm_en |=> (valid_q[$past(cm_set)] && (tag_q[$past(cm_set)] == $past(cm_tag))));

   // R5: valid bits move only on a commit
   a_r5_valid_only_on_commit: assert property (@(posedge clk) disable iff (rst)
      !cm_en |=> $stable(valid_q));

   // R3: a hit never appears without a lookup request
   a_r3_hit_needs_request: assert property (@(posedge clk) disable iff (rst)
      lk_hit |-> lk_valid);

   // R3: at most one set can match a tag
   a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
      $onehot0(way_match));

endmodule

// File: rtl/tcache_data_store.sv
module tcache_data_store
   import tcache_pkg::*;
#(
   parameter int unsigned NUM_SETS   = 4,
   parameter int unsigned TILE_WORDS = 3,
   parameter int unsigned WORD_WIDTH = 24,
   localparam int unsigned SET_W     = idx_w(NUM_SETS),
   localparam int unsigned WORD_W    = idx_w(TILE_WORDS),
   localparam int unsigned DEPTH     = NUM_SETS * TILE_WORDS,
   localparam int unsigned LIN_W     = idx_w(DEPTH) + 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic [SET_W-1:0]      wr_set,
   input  logic [WORD_W-1:0]     wr_word,
   input  logic [WORD_WIDTH-1:0] wr_data,
   input  logic                  rd_en,
   input  logic [SET_W-1:0]      rd_set,
   input  logic [WORD_W-1:0]     rd_word,
   output logic [WORD_WIDTH-1:0] rd_data
);

   logic [WORD_WIDTH-1:0] mem_q [DEPTH];
   logic [WORD_WIDTH-1:0] rd_q;
   logic [WORD_WIDTH-1:0] rd_word_now;
   logic [LIN_W-1:0]      wr_lin;
   logic [LIN_W-1:0]      rd_lin;
   logic                  wr_ok;
   logic                  rd_ok;

   assign wr_lin = LIN_W'(wr_set) * LIN_W'(TILE_WORDS) + LIN_W'(wr_word);
   assign rd_lin = LIN_W'(rd_set) * LIN_W'(TILE_WORDS) + LIN_W'(rd_word);
   assign wr_ok  = (LIN_W'(wr_word) < LIN_W'(TILE_WORDS)) && (wr_lin < LIN_W'(DEPTH));
   assign rd_ok  = (LIN_W'(rd_word) < LIN_W'(TILE_WORDS)) && (rd_lin < LIN_W'(DEPTH));

   assign rd_word_now = rd_ok ? mem_q[rd_lin] : '0;

   always_ff @(posedge clk) begin
      if (wr_en && wr_ok)
         mem_q[wr_lin] <= wr_data;
   end

   // Read samples the array before any same-edge write lands.
   always_ff @(posedge clk) begin
      if (rst)
         rd_q <= '0;
      else if (rd_en)
         rd_q <= rd_word_now;
   end

   assign rd_data = rd_q;

   // R6: output holds while no read is requested
   a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_q));

   // R6: output one edge after a read is the word present at request time
   a_r6_one_cycle_latency: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> (rd_q == $past(rd_word_now)));

endmodule

// File: rtl/tile_cache_array.sv
module tile_cache_array
   import tcache_pkg::*;
#(
   parameter int unsigned NUM_SETS   = 4,
   parameter int unsigned TILE_WORDS = 3,
   parameter int unsigned WORD_WIDTH = 24,
   parameter int unsigned TAG_WIDTH  = 8,
   parameter int unsigned CNT_WIDTH  = 32,
   localparam int unsigned SET_W     = idx_w(NUM_SETS),
   localparam int unsigned WORD_W    = idx_w(TILE_WORDS)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  lk_valid,
   input  logic [TAG_WIDTH-1:0]  lk_tag,
   output logic                  lk_hit,
   input  logic                  rd_en,
   input  logic [SET_W-1:0]      rd_set,
   input  logic [WORD_W-1:0]     rd_word,
   output logic [WORD_WIDTH-1:0] rd_data,
   input  logic                  fl_we,
   input  logic [SET_W-1:0]      fl_set,
   input  logic [WORD_W-1:0]     fl_word,
   input  logic [WORD_WIDTH-1:0] fl_data,
   input  logic                  fl_commit,
   input  logic [TAG_WIDTH-1:0]  fl_tag,
   output logic [CNT_WIDTH-1:0]  hit_count,
   output logic [CNT_WIDTH-1:0]  miss_count
);

   // Elaboration-time parameter checks
   if ((NUM_SETS < 2) || ((NUM_SETS & (NUM_SETS - 1)) != 0)) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if (TILE_WORDS < 1) begin : g_bad_words
      $error("TILE_WORDS must be at least 1");
   end
   if (TAG_WIDTH < SET_W) begin : g_bad_tag
      $error("TAG_WIDTH must cover the set index");
   end
   if ((CNT_WIDTH < 2) || (WORD_WIDTH < 1)) begin : g_bad_width
      $error("CNT_WIDTH must be at least 2 and WORD_WIDTH at least 1");
   end

   logic hit_w;
   logic miss_inc;

   tcache_tag_store #(
      .NUM_SETS  (NUM_SETS),
      .TAG_WIDTH (TAG_WIDTH)
   ) u_tags (
      .clk      (clk),
      .rst      (rst),
      .lk_valid (lk_valid),
      .lk_tag   (lk_tag),
      .lk_hit   (hit_w),
      .cm_en    (fl_commit),
      .cm_tag   (fl_tag)
   );

   tcache_data_store #(
      .NUM_SETS   (NUM_SETS),
      .TILE_WORDS (TILE_WORDS),
      .WORD_WIDTH (WORD_WIDTH)
   ) u_data (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (fl_we),
      .wr_set  (fl_set),
      .wr_word (fl_word),
      .wr_data (fl_data),
      .rd_en   (rd_en),
      .rd_set  (rd_set),
      .rd_word (rd_word),
      .rd_data (rd_data)
   );

   assign lk_hit   = hit_w;
   assign miss_inc = lk_valid && !hit_w;

   tcache_sat_counter #(.CNT_WIDTH(CNT_WIDTH)) u_hit_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (hit_w),
      .count (hit_count)
   );

   tcache_sat_counter #(.CNT_WIDTH(CNT_WIDTH)) u_miss_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (miss_inc),
      .count (miss_count)
   );

   // R7: every lookup moves at most one of the two counters
   a_r7_one_counter_per_lookup: assert property (@(posedge clk) disable iff (rst)
      lk_valid |=> ($stable(hit_count) || $stable(miss_count)));

   // R7: with no lookup both counters stay put
   a_r7_no_lookup_no_count: assert property (@(posedge clk) disable iff (rst)
      !lk_valid |=> ($stable(hit_count) && $stable(miss_count)));

endmodule

// File: tb/tile_cache_array_tb.sv
module tile_cache_array_tb;

   localparam int unsigned NS  = 4;
   localparam int unsigned TW  = 3;
   localparam int unsigned WW  = 16;
   localparam int unsigned TGW = 4;
   localparam int unsigned CW  = 4;
   localparam int unsigned CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          lk_valid = 1'b0;
   logic [TGW-1:0] lk_tag = '0;
   logic          lk_hit;
   logic          rd_en = 1'b0;
   logic [1:0]    rd_set = '0;
   logic [1:0]    rd_word = '0;
   logic [WW-1:0] rd_data;
   logic          fl_we = 1'b0;
   logic [1:0]    fl_set = '0;
   logic [1:0]    fl_word = '0;
   logic [WW-1:0] fl_data = '0;
   logic          fl_commit = 1'b0;
   logic [TGW-1:0] fl_tag = '0;
   logic [CW-1:0] hit_count;
   logic [CW-1:0] miss_count;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Bench-side model of the requirements
   bit          m_valid [NS];
   int unsigned m_tag   [NS];
   int unsigned m_mem   [NS*TW];
   int unsigned m_hits  = 0;
   int unsigned m_miss  = 0;

   always #5 clk = ~clk;

   tile_cache_array #(
      .NUM_SETS   (NS),
      .TILE_WORDS (TW),
      .WORD_WIDTH (WW),
      .TAG_WIDTH  (TGW),
      .CNT_WIDTH  (CW)
   ) u_dut (
      .clk        (clk),
      .rst        (rst),
      .lk_valid   (lk_valid),
      .lk_tag     (lk_tag),
      .lk_hit     (lk_hit),
      .rd_en      (rd_en),
      .rd_set     (rd_set),
      .rd_word    (rd_word),
      .rd_data    (rd_data),
      .fl_we      (fl_we),
      .fl_set     (fl_set),
      .fl_word    (fl_word),
      .fl_data    (fl_data),
      .fl_commit  (fl_commit),
      .fl_tag     (fl_tag),
      .hit_count  (hit_count),
      .miss_count (miss_count)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int unsigned sat_inc(input int unsigned v);
      return (v == CMAX) ? v : v + 1;
   endfunction

   function automatic bit exp_hit(input int unsigned t);
      return m_valid[t % NS] && (m_tag[t % NS] == t);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      for (int s = 0; s < NS; s++) m_valid[s] = 1'b0;
      m_hits = 0;
      m_miss = 0;
   endtask

   // Counters checked before the lookup (R7/R8), hit checked same cycle (R3)
   task automatic do_lookup(input int unsigned t, input bit v, input string req);
      @(negedge clk);
      chk("R7/R8 hit_count", 32'(hit_count), m_hits);
      chk("R7/R8 miss_count", 32'(miss_count), m_miss);
      lk_valid = v;
      lk_tag   = TGW'(t);
      #1;
      chk(req, 32'(lk_hit), 32'(v && exp_hit(t)));
      @(posedge clk);
      #1 lk_valid = 1'b0;
      if (v) begin
         if (exp_hit(t)) m_hits = sat_inc(m_hits);
         else            m_miss = sat_inc(m_miss);
      end
   endtask

   task automatic fill_word(input int unsigned s, input int unsigned w, input int unsigned d);
      @(negedge clk);
      fl_we = 1'b1; fl_set = 2'(s); fl_word = 2'(w); fl_data = WW'(d);
      @(posedge clk);
      #1 fl_we = 1'b0;
      m_mem[s*TW + w] = d;
   endtask

   task automatic commit(input int unsigned t);
      @(negedge clk);
      fl_commit = 1'b1; fl_tag = TGW'(t);
      @(posedge clk);
      #1 fl_commit = 1'b0;
      m_valid[t % NS] = 1'b1;
      m_tag[t % NS]   = t;
   endtask

   task automatic read_chk(input int unsigned s, input int unsigned w, input string req);
      @(negedge clk);
      rd_en = 1'b1; rd_set = 2'(s); rd_word = 2'(w);
      @(posedge clk);
      #1 rd_en = 1'b0;
      @(negedge clk);
      chk(req, 32'(rd_data), m_mem[s*TW + w]);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();

      // Reset state: counters zero, data output zero (R7, R6)
      @(negedge clk);
      chk("R7 reset hit_count", 32'(hit_count), 0);
      chk("R7 reset miss_count", 32'(miss_count), 0);
      chk("R6 reset rd_data", 32'(rd_data), 0);

      // Every tag misses after reset; miss count climbs and saturates (R4, R8)
      for (int t = 0; t < 16; t++) do_lookup(t, 1'b1, "R4 miss after reset");
      for (int t = 0; t < 2; t++) do_lookup(t, 1'b1, "R8 miss saturation");

      do_reset();

      // Fill sets 0..3 with tags 0..3; tag invisible until commit (R5, R1)
      for (int s = 0; s < NS; s++) begin
         for (int w = 0; w < TW; w++) fill_word(s, w, 32'h1000 + s*16 + w);
         do_lookup(s, 1'b1, "R5 no hit before commit");
         commit(s);
      end

      // Exhaustive tag sweep: only resident tags hit (R2, R3)
      for (int t = 0; t < 16; t++) do_lookup(t, 1'b1, "R3 sweep hit");
      for (int t = 0; t < 4; t++) do_lookup(t, 1'b0, "R3 no hit without lk_valid");

      // Every stored word reads back (R1)
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < TW; w++) read_chk(s, w, "R1 read back");

      // Alias eviction: tag 5 shares set 1 with tag 1 (R2, R5)
      for (int w = 0; w < TW; w++) fill_word(1, w, 32'h2000 + w);
      do_lookup(5, 1'b1, "R5 tag 5 absent before commit");
      do_lookup(1, 1'b1, "R5 tag 1 still resident during fill");
      commit(5);
      do_lookup(5, 1'b1, "R2 tag 5 hit after commit");
      do_lookup(1, 1'b1, "R2 tag 1 evicted by alias");
      for (int w = 0; w < TW; w++) read_chk(1, w, "R1 refilled set 1");

      // Same-cycle commit and lookup see the old state (R9)
      @(negedge clk);
      fl_commit = 1'b1; fl_tag = 4'd6;
      lk_valid = 1'b1;  lk_tag = 4'd6;
      #1;
      chk("R9 same-cycle lookup sees pre-commit", 32'(lk_hit), 0);
      @(posedge clk);
      #1 fl_commit = 1'b0; lk_valid = 1'b0;
      m_miss = sat_inc(m_miss);
      m_valid[2] = 1'b1; m_tag[2] = 6;
      do_lookup(6, 1'b1, "R9 commit effective next cycle");
      do_lookup(2, 1'b1, "R2 tag 2 evicted by tag 6");

      // Read and write to the same word together returns the old word (R6)
      @(negedge clk);
      rd_en = 1'b1; rd_set = 2'd3; rd_word = 2'd2;
      fl_we = 1'b1; fl_set = 2'd3; fl_word = 2'd2; fl_data = 16'h3ABC;
      @(posedge clk);
      #1 rd_en = 1'b0; fl_we = 1'b0;
      @(negedge clk);
      chk("R6 read-during-write returns old", 32'(rd_data), m_mem[3*TW + 2]);
      m_mem[3*TW + 2] = 32'h3ABC;
      read_chk(3, 2, "R6 new word after write");

      // Output holds while rd_en is low even as address moves (R6)
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         rd_set = 2'(i); rd_word = 2'(i);
         @(negedge clk);
         chk("R6 hold with rd_en low", 32'(rd_data), 32'h3ABC);
      end

      // Reset clears valid bits but keeps words (R4)
      do_reset();
      do_lookup(0, 1'b1, "R4 tag 0 miss after reset");
      do_lookup(5, 1'b1, "R4 tag 5 miss after reset");
      read_chk(0, 1, "R4 data retained over reset");
      read_chk(1, 2, "R4 refilled data retained");

      // Hit count saturation (R8)
      commit(0);
      for (int i = 0; i < 18; i++) do_lookup(0, 1'b1, "R8 hit saturation");
      @(negedge clk);
      chk("R8 hit_count held at max", 32'(hit_count), CMAX);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule